// File: doc/BRIEF.md
# Fractional Clock-Enable Generator with Committed Ratio Update

The block turns a free-running input clock into a single-cycle enable stream whose average rate is the clock rate scaled by M/32, where M is any whole number from 1 to 32. Downstream logic that runs on the same clock treats the enable as its own slower clock. The pulses are spread as evenly as possible over a repeating 32-cycle frame, so every frame carries exactly M of them.

Software changes the ratio in two steps. First it writes the new ratio into the ratio register, as the value 32 − M. Then it sets a commit flag in a separate command register. The enable stream keeps its old ratio until the next frame boundary. On that boundary the new ratio takes over and the hardware clears the commit flag. Software polls the flag to learn when the change is done. While a commit is still pending, the ratio register is locked: a write to it is refused and a reject strobe is raised in the same cycle. The worst-case update latency is one frame plus one cycle.

The bus is a single-cycle write port with a combinational read path. The reset input is asynchronous and active-low. It is expected to be deasserted in step with the clock by the reset controller.

Top module: `frac_clken_gen`

## Requirements
- R1: While reset is asserted and after its release, the ratio field reads 0 (full rate, M = 32), the commit flag reads 0, and `clk_en` is high on every cycle until a different ratio is committed.
- R2: With a ratio M in effect, every 32-cycle frame carries exactly M cycles with `clk_en` high. The first frame begins on the first cycle after reset release.
- R3: The ratio register is at word address 1. The stored value sits in bits 12:8 and equals 32 − M. A write to this register takes only bits 12:8, and a read returns the stored value with all other bits 0.
- R4: A value written to the ratio register has no effect on `clk_en` until a commit has been requested and carried out.
- R5: The command register is at word address 0. Writing it with bit 31 set raises the commit flag, which reads back in bit 31. Writing it with bit 31 clear has no effect. Other addresses read 0.
- R6: A pending commit takes effect on the clock edge that ends a frame: the new ratio governs from the first slot of the next frame, and the flag clears on that same edge. The flag therefore reads 0 no more than 33 cycles after the commit write. A commit request that arrives on the committing edge keeps the flag set for another frame.
- R7: While the commit flag is set, a write to the ratio register is refused: `bus_rej` is high in that cycle and the stored value does not change.
- R8: Within a frame, slot c (0 to 31) carries a pulse exactly when floor((c+1)·M/32) > floor(c·M/32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bus_rej | output | 1 | High when a write to the ratio register is refused |
| clk_en | output | 1 | Fractional-rate clock enable |

## Verification
The hardest cases to reach are the ones that depend on where the frame boundary falls, because the boundary cannot be seen at the ports. The bench's reference model counts slots from reset release. This lets it place writes on chosen slots: a commit written on the last slot of a frame, and a second commit written on the very edge that carries out the first. It then checks the extra-frame latency and the repeated commit cycle by cycle. Refused ratio writes are issued directly after a commit, while the flag is known to be set.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
  localparam int DATA_W    = 32;
  localparam int FRAC_W    = 5;
  localparam int FIELD_LSB = 8;
  localparam int KICK_BIT  = 31;
  localparam int ADDR_W    = 2;
  localparam int KICK_ADDR = 0;
  localparam int FREQ_ADDR = 1;
endpackage

// File: rtl/frac_frame_ctr.sv
module frac_frame_ctr #(
  parameter int FRAC_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_end
);
  logic [FRAC_W-1:0] slot_q, slot_d;

  always_comb begin
    slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign frame_end = &slot_q;
endmodule

// File: rtl/frac_ctl_regs.sv
module frac_ctl_regs #(
  parameter int DATA_W    = 32,
  parameter int FRAC_W    = 5,
  parameter int FIELD_LSB = 8,
  parameter int KICK_BIT  = 31,
  parameter int ADDR_W    = 2,
  parameter int KICK_ADDR = 0,
  parameter int FREQ_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              frame_end,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rej,
  output logic [FRAC_W-1:0] staged_field,
  output logic              commit
);
  logic              pending_q, pending_d;
  logic [FRAC_W-1:0] staged_q, staged_d;
  logic              kick_set, freq_hit, staged_we;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign kick_set  = bus_wr && (bus_addr == ADDR_W'(KICK_ADDR)) && bus_wdata[KICK_BIT];
  assign freq_hit  = bus_wr && (bus_addr == ADDR_W'(FREQ_ADDR));
  assign bus_rej   = freq_hit && pending_q;
  assign staged_we = freq_hit && !pending_q;
  assign commit    = frame_end && pending_q;

  always_comb begin
    staged_d = staged_we ? bus_wdata[FIELD_LSB +: FRAC_W] : staged_q;
    if (kick_set)    pending_d = 1'b1;
    else if (commit) pending_d = 1'b0;
    else             pending_d = pending_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      staged_q  <= staged_d;
      pending_q <= pending_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(KICK_ADDR))      bus_rdata[KICK_BIT] = pending_q;
    else if (bus_addr == ADDR_W'(FREQ_ADDR)) bus_rdata[FIELD_LSB +: FRAC_W] = staged_q;
  end

  assign staged_field = staged_q;

  // R7: the stored ratio cannot move while a commit is outstanding
  assert_staged_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |=> $stable(staged_q));
  // R6: the flag only drops on a frame-ending edge
  assert_kick_clears_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_q) |-> $past(frame_end));
  // R5: a commit request always leaves the flag raised
  assert_kick_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_set |=> pending_q);
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FRAC_W-1:0] load_field,
  input  logic              frame_end,
  output logic              clk_en
);
  localparam logic [FRAC_W:0] FRAME_V = (FRAC_W+1)'(1) << FRAC_W;

  logic [FRAC_W-1:0] active_q, active_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   mult, sum;

  always_comb begin
    mult     = FRAME_V - {1'b0, active_q};
    sum      = {1'b0, acc_q} + mult;
    acc_d    = sum[FRAC_W-1:0];
    active_d = load ? load_field : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      active_q <= '0;
    end else begin
      acc_q    <= acc_d;
      active_q <= active_d;
    end
  end

  assign clk_en = sum[FRAC_W];

  // R8: the accumulator returns to zero at each frame start
  assert_frame_realigns_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (acc_q == '0));
  // R4: the active ratio moves only on a commit
  assert_ratio_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));
endmodule

// File: rtl/frac_clken_gen.sv
module frac_clken_gen
  import frac_clk_pkg::*;
#(
  parameter int FRAC_W    = frac_clk_pkg::FRAC_W,
  parameter int FIELD_LSB = frac_clk_pkg::FIELD_LSB,
  parameter int KICK_BIT  = frac_clk_pkg::KICK_BIT,
  parameter int ADDR_W    = frac_clk_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rej,
  output logic              clk_en
);
  logic              frame_end;
  logic              commit;
  logic [FRAC_W-1:0] staged_field;

  frac_frame_ctr #(.FRAC_W(FRAC_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end)
  );

  frac_ctl_regs #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT),
    .ADDR_W(ADDR_W), .KICK_ADDR(KICK_ADDR), .FREQ_ADDR(FREQ_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .frame_end(frame_end), .bus_rdata(bus_rdata),
    .bus_rej(bus_rej), .staged_field(staged_field), .commit(commit)
  );

  frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .load(commit), .load_field(staged_field),
    .frame_end(frame_end), .clk_en(clk_en)
  );

  // R7: a refused write never coincides with an accepted ratio change
  assert_reject_keeps_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rej |=> $stable(bus_rdata[FIELD_LSB +: FRAC_W]) || (bus_addr != ADDR_W'(FREQ_ADDR)));
endmodule

// File: tb/frac_clken_gen_test.sv
module frac_clken_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rej;
  logic        clk_en;

  int vectors = 0;
  int errs = 0;
  int slot = 0, m_pending = 0, m_staged = 0, m_active = 0, fpulses = 0;
  logic [31:0] last_rd;

  always #10 clk = ~clk;

  frac_clken_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rej(bus_rej), .clk_en(clk_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input int addr, input logic [31:0] d);
    int m;
    bit exp_en, exp_rej, commit;
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_wr = wr; bus_addr = 2'(addr); bus_wdata = d;
    #2;
    m = 32 - m_active;
    exp_en  = (((slot + 1) * m) / 32) > ((slot * m) / 32);
    exp_rej = wr && addr == 1 && m_pending != 0;
    exp_rd  = (addr == 0) ? {m_pending[0], 31'b0} :
              (addr == 1) ? (32'(m_staged) << 8) : 32'b0;
    check(clk_en == exp_en, "R8", int'(clk_en), int'(exp_en));
    check(bus_rej == exp_rej, "R7", int'(bus_rej), int'(exp_rej));
    check(bus_rdata == exp_rd, (addr == 1) ? "R3" : "R5", bus_rdata, exp_rd);
    last_rd = bus_rdata;
    fpulses += int'(clk_en);
    if (slot == 31) begin
      check(fpulses == m, "R2,R4 pulses per frame", fpulses, m);
      fpulses = 0;
    end
    commit = (slot == 31) && m_pending != 0;
    if (wr && addr == 1 && m_pending == 0) m_staged = int'(d[12:8]);
    if (commit) m_active = m_staged;
    if (wr && addr == 0 && d[31]) m_pending = 1;
    else if (commit) m_pending = 0;
    slot = (slot + 1) % 32;
  endtask

  task automatic idle(input int n, input int addr);
    for (int i = 0; i < n; i++) step(1'b0, addr, 32'h0);
  endtask

  task automatic to_slot(input int s);
    while (slot != s) step(1'b0, 0, 32'h0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(clk_en == 1'b1, "R1 clk_en in reset", int'(clk_en), 1);
    check(bus_rdata == 32'h0, "R1 flag in reset", bus_rdata, 0);
    bus_addr = 2'd1; #1;
    check(bus_rdata == 32'h0, "R1 ratio in reset", bus_rdata, 0);
    @(posedge clk); #3; rst_n = 1'b1;

    idle(32, 1);
    idle(8, 3);
    // R3/R4: stage M=12, no commit yet
    step(1'b1, 1, 32'h0000_1400);
    idle(40, 1);
    // R5: clear bit 31 write has no effect
    step(1'b1, 0, 32'h7FFF_FFFF);
    step(1'b0, 0, 32'h0);
    // R6: commit and poll
    step(1'b1, 0, 32'h8000_0000);
    step(1'b1, 1, 32'h0000_0300); // R7: refused
    lat = 1;
    do begin step(1'b0, 0, 32'h0); lat++; end while (last_rd[31] && lat < 40);
    check(lat <= 33, "R6 latency", lat, 33);
    idle(64, 1);
    // M=1, commit placed on the last slot of a frame
    step(1'b1, 1, 32'h0000_1F00);
    to_slot(31);
    step(1'b1, 0, 32'h8000_0000);
    idle(70, 0);
    // M=17 with noise bits outside field (R3)
    step(1'b1, 1, 32'hFFFF_EFFF);
    step(1'b1, 0, 32'h8000_0000);
    // R6: second commit on committing edge keeps flag set a frame longer
    to_slot(31);
    step(1'b1, 0, 32'h8000_0000);
    step(1'b1, 1, 32'h0000_0000);
    idle(70, 0);
    // back to full rate
    step(1'b1, 1, 32'h0000_0000);
    step(1'b1, 0, 32'hFFFF_FFFF);
    idle(70, 1);
    summary();
    $finish;
  end
endmodule